// File: doc/BRIEF.md
# Front-end link bus responder

This block sits on the front-end side of a synchronous, 32-bit, half-duplex link bus. A link unit owns the bus most of the time and uses it to send command words. The responder decodes those words. It takes control settings, accepts streamed block-write data, and answers read requests. A read request can be a single status word, a one-block read, or a multi-block event read. For event and block reads, data comes from a show-ahead FIFO that sits next to the block.

The link decides who drives the bus with a direction input and an active-low bus-enable input. The responder presents its words on registered data, enable and qualifier outputs. A separate output-enable goes to the pad tri-state buffers. That enable is high only while the link grants the bus toward the front end and a read transaction is waiting for the bus. During reads the link throttles the responder with an active-low link-full input. During block writes the responder throttles the link with an active-low busy output.

Top module: `fe_link_responder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `bus_oe` is 0, `fe_busy_n` is 1, and `ctrl_valid`, `wr_valid` and `ev_pop` are 0, even if the link grants the bus.
- R2: `bus_oe` is 1 only while `lnk_dir`=1, `lnk_ben_n`=0 and a read transaction is outstanding. A read transaction is a status read, event read or block read. Before the grant, and with no read outstanding, `bus_oe` is 0.
- R3: A command word is a bus word with `lnk_dir`=0, `lnk_ben_n`=0 and `bus_ctl_n_in`=0. Bits [7:0] hold the operation code: 0x01 control write, 0x02 status read, 0x03 event read, 0x04 block write, 0x05 block read, 0x06 end of block. Any other code is ignored, and a later grant leaves `bus_oe` at 0.
- R4: A control-write command pulses `ctrl_valid` for one cycle, in the cycle after the command. In that cycle `ctrl_param` equals command bits [31:8].
- R5: After a status-read command, the first clock edge at which the bus is granted loads one word. The word is `{fe_stat, 8'h80}`, with `bus_ten_n_out`=0 and `bus_ctl_n_out`=0, and it is visible in the cycle after that edge. In later cycles `bus_ten_n_out` is 1 while the grant lasts.
- R6: During an event read or block read, each word popped from the FIFO appears one cycle later as a data word (`bus_ten_n_out`=0, `bus_ctl_n_out`=1). The words keep FIFO order. The word flagged by `ev_last` closes the block. In the next granted cycle the responder sends the status word `{block_word_count, 8'h81}`.
- R7: In an event read, while data is available and link-full is released, exactly MIN_GAP (16) cycles without a bus word separate a block status word from the first data word of the next block. In every case there are at least that many.
- R8: A data word appears only if `lnk_full_n` was 1 at the clock edge that loaded it. Stalls lose, repeat or reorder no word.
- R9: After a block-write command, each data word from the link (`bus_ten_n_in`=0, `bus_ctl_n_in`=1) appears on `wr_data` with `wr_valid`=1 one cycle later. In that mode `fe_busy_n` follows `wr_ready`, and outside it `fe_busy_n` is 1. Data words that arrive outside block-write mode produce no `wr_valid`.
- R10: A block read sends one block and its status word, then no more data until end of block, even when the FIFO holds more words.
- R11: An end-of-block command returns the responder to idle from any transaction, so a following grant leaves `bus_oe` at 0.
- R12: If the link withdraws the grant during a read, `bus_oe` goes to 0 and no FIFO word is popped. When the grant is restored, the stream continues without losing a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_dir | input | 1 | Bus direction from the link, 1 = front end may drive |
| lnk_ben_n | input | 1 | Active-low bus enable from the link |
| lnk_full_n | input | 1 | Active-low link-full flow control |
| fe_busy_n | output | 1 | Active-low busy toward the link during block write |
| bus_d_in | input | 32 | Bus data as received |
| bus_ten_n_in | input | 1 | Received active-low transfer enable |
| bus_ctl_n_in | input | 1 | Received active-low qualifier |
| bus_d_out | output | 32 | Bus data to drive |
| bus_ten_n_out | output | 1 | Active-low transfer enable to drive |
| bus_ctl_n_out | output | 1 | Active-low qualifier to drive |
| bus_oe | output | 1 | Pad drive enable for data, enable and qualifier |
| ev_data | input | 32 | FIFO head word |
| ev_last | input | 1 | FIFO head word closes its block |
| ev_empty | input | 1 | FIFO is empty |
| ev_pop | output | 1 | Pop the FIFO head at this edge |
| fe_stat | input | 24 | Status body for status-read replies |
| ctrl_valid | output | 1 | Control-write setting strobe |
| ctrl_param | output | 24 | Control-write setting value |
| wr_valid | output | 1 | Block-write data strobe |
| wr_data | output | 32 | Block-write data word |
| wr_ready | input | 1 | Block-write sink can accept data |

## Verification
The situation hardest to reach from the ports is a grant withdrawn in the middle of an event stream. It has to happen at a point where no word is in flight, so that any loss would show up as a gap in the sequence. The bench reaches it by first holding link-full low for two cycles. It then removes the direction grant, checks that the pads are released and nothing is popped, and restores the grant. The sweep over block sizes and block counts, with and without a periodic link-full pattern, covers the inter-block gap under both exact and delayed conditions.

// File: rtl/fe_link_pkg.sv
package fe_link_pkg;
  localparam int TAG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STRD_WAIT, ST_STRD_DONE, ST_DATA,
    ST_BSTS, ST_GAP, ST_BDONE, ST_WR
  } fe_state_e;

  localparam logic [TAG_W-1:0] OP_CTRL = 8'h01;
  localparam logic [TAG_W-1:0] OP_STRD = 8'h02;
  localparam logic [TAG_W-1:0] OP_EVRD = 8'h03;
  localparam logic [TAG_W-1:0] OP_BWR  = 8'h04;
  localparam logic [TAG_W-1:0] OP_BRD  = 8'h05;
  localparam logic [TAG_W-1:0] OP_EOB  = 8'h06;

  localparam logic [TAG_W-1:0] TAG_STAT  = 8'h80;
  localparam logic [TAG_W-1:0] TAG_BLOCK = 8'h81;
endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
  import fe_link_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                lnk_dir,
  input  logic                lnk_ben_n,
  input  logic [DW-1:0]       bus_d_in,
  input  logic                bus_ten_n_in,
  input  logic                bus_ctl_n_in,
  output logic                op_ctrl,
  output logic                op_strd,
  output logic                op_evrd,
  output logic                op_bwr,
  output logic                op_brd,
  output logic                op_eob,
  output logic                data_word,
  output logic [DW-TAG_W-1:0] op_param
);
  logic link_talks;
  logic cmd_word;
  logic [TAG_W-1:0] code;

  assign link_talks = !lnk_dir && !lnk_ben_n;
  assign cmd_word   = link_talks && !bus_ctl_n_in;
  assign code       = bus_d_in[TAG_W-1:0];
  assign op_param   = bus_d_in[DW-1:TAG_W];
  assign data_word  = link_talks && !bus_ten_n_in && bus_ctl_n_in;

  always_comb begin
    op_ctrl = cmd_word && (code == OP_CTRL);
    op_strd = cmd_word && (code == OP_STRD);
    op_evrd = cmd_word && (code == OP_EVRD);
    op_bwr  = cmd_word && (code == OP_BWR);
    op_brd  = cmd_word && (code == OP_BRD);
    op_eob  = cmd_word && (code == OP_EOB);
  end
endmodule

// File: rtl/fe_tx_engine.sv
module fe_tx_engine
  import fe_link_pkg::*;
#(
  parameter int DW      = 32,
  parameter int MIN_GAP = 16,
  parameter int BLK_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                owned,
  input  logic                lnk_dir,
  input  logic                lnk_full_n,
  input  logic                op_ctrl,
  input  logic                op_strd,
  input  logic                op_evrd,
  input  logic                op_bwr,
  input  logic                op_brd,
  input  logic                op_eob,
  input  logic                data_word,
  input  logic [DW-TAG_W-1:0] op_param,
  input  logic [DW-1:0]       bus_d_in,
  input  logic [DW-1:0]       ev_data,
  input  logic                ev_last,
  input  logic                ev_empty,
  input  logic [DW-TAG_W-1:0] fe_stat,
  input  logic                wr_ready,
  output logic [DW-1:0]       tx_d,
  output logic                tx_ten_n,
  output logic                tx_ctl_n,
  output logic                drive_state,
  output logic                ev_pop,
  output logic                ctrl_valid,
  output logic [DW-TAG_W-1:0] ctrl_param,
  output logic                wr_valid,
  output logic [DW-1:0]       wr_data,
  output logic                fe_busy_n
);
  localparam int BODY_W = DW - TAG_W;
  localparam int GAP_W  = $clog2(MIN_GAP + 1);

  fe_state_e        state;
  logic             ev_mode;
  logic [BLK_W-1:0] blk_cnt;
  logic [GAP_W-1:0] gap_cnt;

  // named internal events
  logic issue_data, issue_sts, issue_plain;

  function automatic logic [DW-1:0] status_word(input logic [BODY_W-1:0] body,
                                                input logic [TAG_W-1:0] tag);
    return {body, tag};
  endfunction

  function automatic logic gap_expired(input logic [GAP_W-1:0] cnt);
    return cnt == GAP_W'(MIN_GAP - 1);
  endfunction

  assign issue_data  = (state == ST_DATA) && owned && lnk_full_n && !ev_empty;
  assign issue_sts   = (state == ST_BSTS) && owned;
  assign issue_plain = (state == ST_STRD_WAIT) && owned;
  assign ev_pop      = issue_data;
  assign drive_state = state inside {ST_STRD_WAIT, ST_STRD_DONE, ST_DATA,
                                     ST_BSTS, ST_GAP, ST_BDONE};
  assign fe_busy_n   = !((state == ST_WR) && !wr_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ev_mode    <= 1'b0;
      blk_cnt    <= '0;
      gap_cnt    <= '0;
      tx_d       <= '0;
      tx_ten_n   <= 1'b1;
      tx_ctl_n   <= 1'b1;
      ctrl_valid <= 1'b0;
      ctrl_param <= '0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
    end else begin
      tx_ten_n   <= 1'b1;
      tx_ctl_n   <= 1'b1;
      ctrl_valid <= 1'b0;
      wr_valid   <= 1'b0;
      if (issue_data) begin
        tx_d     <= ev_data;
        tx_ten_n <= 1'b0;
        blk_cnt  <= blk_cnt + 1'b1;
      end
      if (issue_sts) begin
        tx_d     <= status_word(BODY_W'(blk_cnt), TAG_BLOCK);
        tx_ten_n <= 1'b0;
        tx_ctl_n <= 1'b0;
        blk_cnt  <= '0;
      end
      if (issue_plain) begin
        tx_d     <= status_word(fe_stat, TAG_STAT);
        tx_ten_n <= 1'b0;
        tx_ctl_n <= 1'b0;
      end
      if (op_eob && state != ST_IDLE) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (op_ctrl) begin
              ctrl_valid <= 1'b1;
              ctrl_param <= op_param;
            end else if (op_strd) begin
              state <= ST_STRD_WAIT;
            end else if (op_evrd || op_brd) begin
              state   <= ST_DATA;
              ev_mode <= op_evrd;
              blk_cnt <= '0;
            end else if (op_bwr) begin
              state <= ST_WR;
            end
          end
          ST_STRD_WAIT: if (issue_plain) state <= ST_STRD_DONE;
          ST_STRD_DONE: if (!lnk_dir) state <= ST_IDLE;
          ST_DATA:      if (issue_data && ev_last) state <= ST_BSTS;
          ST_BSTS: begin
            if (issue_sts) begin
              state   <= ev_mode ? ST_GAP : ST_BDONE;
              gap_cnt <= '0;
            end
          end
          ST_GAP: begin
            if (gap_expired(gap_cnt)) state <= ST_DATA;
            else gap_cnt <= gap_cnt + 1'b1;
          end
          ST_WR: begin
            if (data_word) begin
              wr_valid <= 1'b1;
              wr_data  <= bus_d_in;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // gap watch: cycles since a block status word left the registers
  logic [GAP_W-1:0] since_sts;
  logic             seen_sts;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_sts <= '0;
      seen_sts  <= 1'b0;
    end else if (!tx_ctl_n) begin
      since_sts <= '0;
      seen_sts  <= ev_mode;
    end else begin
      if (state == ST_IDLE) seen_sts <= 1'b0;
      if (since_sts != GAP_W'(MIN_GAP)) since_sts <= since_sts + 1'b1;
    end
  end

  // R6
  pop_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> (!tx_ten_n && tx_ctl_n));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ten_n && tx_ctl_n) |-> $past(lnk_full_n));

  // R7
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_sts && !tx_ten_n && tx_ctl_n) |-> (since_sts == GAP_W'(MIN_GAP)));

  // R9
  wr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(state == ST_WR));
endmodule

// File: rtl/fe_link_responder.sv
module fe_link_responder
  import fe_link_pkg::*;
#(
  parameter int DW      = 32,
  parameter int MIN_GAP = 16,
  parameter int BLK_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lnk_dir,
  input  logic                lnk_ben_n,
  input  logic                lnk_full_n,
  output logic                fe_busy_n,
  input  logic [DW-1:0]       bus_d_in,
  input  logic                bus_ten_n_in,
  input  logic                bus_ctl_n_in,
  output logic [DW-1:0]       bus_d_out,
  output logic                bus_ten_n_out,
  output logic                bus_ctl_n_out,
  output logic                bus_oe,
  input  logic [DW-1:0]       ev_data,
  input  logic                ev_last,
  input  logic                ev_empty,
  output logic                ev_pop,
  input  logic [DW-TAG_W-1:0] fe_stat,
  output logic                ctrl_valid,
  output logic [DW-TAG_W-1:0] ctrl_param,
  output logic                wr_valid,
  output logic [DW-1:0]       wr_data,
  input  logic                wr_ready
);
  logic owned, drive_state;
  logic op_ctrl, op_strd, op_evrd, op_bwr, op_brd, op_eob, data_word;
  logic [DW-TAG_W-1:0] op_param;

  assign owned  = lnk_dir && !lnk_ben_n;
  assign bus_oe = owned && drive_state;

  fe_cmd_decode #(.DW(DW)) u_dec (
    .lnk_dir(lnk_dir), .lnk_ben_n(lnk_ben_n), .bus_d_in(bus_d_in),
    .bus_ten_n_in(bus_ten_n_in), .bus_ctl_n_in(bus_ctl_n_in),
    .op_ctrl(op_ctrl), .op_strd(op_strd), .op_evrd(op_evrd), .op_bwr(op_bwr),
    .op_brd(op_brd), .op_eob(op_eob), .data_word(data_word), .op_param(op_param)
  );

  fe_tx_engine #(.DW(DW), .MIN_GAP(MIN_GAP), .BLK_W(BLK_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .owned(owned), .lnk_dir(lnk_dir),
    .lnk_full_n(lnk_full_n), .op_ctrl(op_ctrl), .op_strd(op_strd),
    .op_evrd(op_evrd), .op_bwr(op_bwr), .op_brd(op_brd), .op_eob(op_eob),
    .data_word(data_word), .op_param(op_param), .bus_d_in(bus_d_in),
    .ev_data(ev_data), .ev_last(ev_last), .ev_empty(ev_empty), .fe_stat(fe_stat),
    .wr_ready(wr_ready), .tx_d(bus_d_out), .tx_ten_n(bus_ten_n_out),
    .tx_ctl_n(bus_ctl_n_out), .drive_state(drive_state), .ev_pop(ev_pop),
    .ctrl_valid(ctrl_valid), .ctrl_param(ctrl_param), .wr_valid(wr_valid),
    .wr_data(wr_data), .fe_busy_n(fe_busy_n)
  );

  // R4
  ctrl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |-> $past(!lnk_dir && !lnk_ben_n && !bus_ctl_n_in &&
                         bus_d_in[TAG_W-1:0] == OP_CTRL));

  // R5
  sts_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ctl_n_out |-> !bus_ten_n_out);
endmodule

// File: tb/fe_link_responder_test.sv
module fe_link_responder_test;
  localparam int DW = 32;
  localparam int MIN_GAP = 16;
  localparam int BW = DW - 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, lnk_dir, lnk_ben_n, lnk_full_n, fe_busy_n;
  logic [DW-1:0] bus_d_in, bus_d_out, ev_data, wr_data;
  logic bus_ten_n_in, bus_ctl_n_in, bus_ten_n_out, bus_ctl_n_out, bus_oe;
  logic ev_last, ev_empty, ev_pop, ctrl_valid, wr_valid, wr_ready;
  logic [BW-1:0] fe_stat, ctrl_param;

  fe_link_responder uut (
    .clk(clk), .rst_n(rst_n), .lnk_dir(lnk_dir), .lnk_ben_n(lnk_ben_n),
    .lnk_full_n(lnk_full_n), .fe_busy_n(fe_busy_n), .bus_d_in(bus_d_in),
    .bus_ten_n_in(bus_ten_n_in), .bus_ctl_n_in(bus_ctl_n_in),
    .bus_d_out(bus_d_out), .bus_ten_n_out(bus_ten_n_out),
    .bus_ctl_n_out(bus_ctl_n_out), .bus_oe(bus_oe), .ev_data(ev_data),
    .ev_last(ev_last), .ev_empty(ev_empty), .ev_pop(ev_pop), .fe_stat(fe_stat),
    .ctrl_valid(ctrl_valid), .ctrl_param(ctrl_param), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready)
  );

  int n_checks = 0;
  int n_err = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (ok !== 1'b1) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0103;
  endfunction

  // FIFO model, show-ahead
  logic [31:0] fifo_mem [0:63];
  logic        fifo_lst [0:63];
  int fifo_n = 0;
  int rd = 0;
  logic fifo_clr = 1'b0;
  always @(posedge clk) begin
    if (fifo_clr) rd <= 0;
    else if (ev_pop) rd <= rd + 1;
  end
  assign ev_empty = (rd >= fifo_n);
  assign ev_data  = fifo_mem[rd[5:0]];
  assign ev_last  = fifo_lst[rd[5:0]];

  // stream monitor, samples 5 ns after each rising edge
  bit mon_on = 0;
  bit after_sts = 0;
  bit gap_exact = 1;
  int mon_base = 0, mon_words = 0, mon_sts = 0, blk_words = 0, idle_cnt = 0, exp_sz = 1;
  always @(posedge clk) begin : mon_blk
    logic full_at_edge;
    full_at_edge = lnk_full_n;
    #5;
    if (mon_on) begin
      if (bus_oe && !bus_ten_n_out) begin
        if (bus_ctl_n_out) begin
          chk(bus_d_out == word_of(mon_base + mon_words), "R6 data order",
              bus_d_out, word_of(mon_base + mon_words));
          chk(full_at_edge, "R8 word under link-full", 32'(full_at_edge), 32'd1);
          if (after_sts) begin
            if (gap_exact)
              chk(idle_cnt == MIN_GAP, "R7 exact gap", 32'(idle_cnt), 32'(MIN_GAP));
            else
              chk(idle_cnt >= MIN_GAP, "R7 min gap", 32'(idle_cnt), 32'(MIN_GAP));
            after_sts = 0;
          end
          mon_words++;
          blk_words++;
        end else begin
          chk(bus_d_out == {BW'(exp_sz), 8'h81}, "R6 block status",
              bus_d_out, {BW'(exp_sz), 8'h81});
          mon_sts++;
          blk_words = 0;
          after_sts = 1;
          idle_cnt = 0;
        end
      end else begin
        idle_cnt++;
      end
    end
  end

  task automatic send_cmd(input logic [7:0] code, input logic [BW-1:0] prm);
    @(negedge clk);
    lnk_dir = 1'b0; lnk_ben_n = 1'b0;
    bus_ctl_n_in = 1'b0; bus_ten_n_in = 1'b0;
    bus_d_in = {prm, code};
    @(negedge clk);
    bus_ctl_n_in = 1'b1; bus_ten_n_in = 1'b1;
  endtask

  int base = 0;

  task automatic load_fifo(input int nb, input int s);
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < s; k++) begin
        fifo_mem[b*s+k] = word_of(base + b*s + k);
        fifo_lst[b*s+k] = (k == s - 1);
      end
    fifo_n = nb * s;
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    mon_base = base; mon_words = 0; mon_sts = 0; blk_words = 0;
    idle_cnt = 0; after_sts = 0; exp_sz = s;
  endtask

  task automatic close_and_idle();
    mon_on = 0;
    lnk_full_n = 1'b1;
    send_cmd(8'h06, '0);
    lnk_dir = 1'b1;
    #1 chk(bus_oe == 1'b0, "R11 idle after end of block", 32'(bus_oe), 32'd0);
    @(negedge clk);
    chk(bus_oe == 1'b0, "R11 idle after end of block", 32'(bus_oe), 32'd0);
    lnk_dir = 1'b0; lnk_ben_n = 1'b1;
    base += 64;
  endtask

  task automatic run_stream(input bit ev, input int nb, input int s, input int fm);
    int exp_words, exp_sts;
    load_fifo(nb, s);
    gap_exact = (fm == 0);
    exp_words = ev ? nb * s : s;
    exp_sts   = ev ? nb : 1;
    mon_on = 1;
    send_cmd(ev ? 8'h03 : 8'h05, '0);
    lnk_dir = 1'b1;
    for (int c = 0; c < 800 && !(mon_words == exp_words && mon_sts == exp_sts); c++) begin
      lnk_full_n = (fm == 0) || (c % 3 != 2);
      @(negedge clk);
    end
    lnk_full_n = 1'b1;
    repeat (MIN_GAP + 8) @(negedge clk);
    if (ev) begin
      chk(mon_words == exp_words, "R6 event word count", 32'(mon_words), 32'(exp_words));
      chk(mon_sts == exp_sts, "R6 event status count", 32'(mon_sts), 32'(exp_sts));
    end else begin
      chk(mon_words == exp_words, "R10 single block only", 32'(mon_words), 32'(exp_words));
      chk(mon_sts == 1, "R10 one status", 32'(mon_sts), 32'd1);
    end
    close_and_idle();
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; lnk_dir = 1'b1; lnk_ben_n = 1'b0; lnk_full_n = 1'b1;
    bus_d_in = '0; bus_ten_n_in = 1'b1; bus_ctl_n_in = 1'b1;
    fe_stat = '0; wr_ready = 1'b1;
    for (int i = 0; i < 64; i++) begin fifo_mem[i] = '0; fifo_lst[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(bus_oe == 1'b0, "R1 oe in reset", 32'(bus_oe), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_oe == 1'b0, "R1 oe after reset", 32'(bus_oe), 32'd0);
    chk(fe_busy_n == 1'b1, "R1 busy after reset", 32'(fe_busy_n), 32'd1);
    chk(!ctrl_valid && !wr_valid && !ev_pop, "R1 strobes after reset",
        {29'd0, ctrl_valid, wr_valid, ev_pop}, 32'd0);
    lnk_dir = 1'b0;

    // control write sweep
    for (int i = 0; i < 6; i++) begin
      logic [BW-1:0] p;
      p = BW'(24'h00_0001 << (i * 4)) ^ BW'(i * 24'h13579);
      send_cmd(8'h01, p);
      chk(ctrl_valid == 1'b1, "R4 strobe", 32'(ctrl_valid), 32'd1);
      chk(ctrl_param == p, "R4 param", 32'(ctrl_param), 32'(p));
      @(negedge clk);
      chk(ctrl_valid == 1'b0, "R4 single pulse", 32'(ctrl_valid), 32'd0);
    end

    // unknown codes ignored
    for (int i = 0; i < 4; i++) begin
      logic [7:0] c;
      c = (i == 0) ? 8'h00 : (i == 1) ? 8'h07 : (i == 2) ? 8'h77 : 8'hFF;
      send_cmd(c, 24'hABCDEF);
      lnk_dir = 1'b1;
      repeat (2) begin
        @(negedge clk);
        chk(bus_oe == 1'b0, "R3 unknown code ignored", 32'(bus_oe), 32'd0);
      end
      chk(ctrl_valid == 1'b0, "R3 no strobe", 32'(ctrl_valid), 32'd0);
      lnk_dir = 1'b0;
    end

    // status read
    for (int i = 0; i < 3; i++) begin
      fe_stat = BW'(24'h1234A5 + i * 24'h0F0F01);
      send_cmd(8'h02, '0);
      @(negedge clk);
      chk(bus_oe == 1'b0, "R2 no drive before grant", 32'(bus_oe), 32'd0);
      lnk_dir = 1'b1;
      #1 chk(bus_oe == 1'b1, "R2 drive on grant", 32'(bus_oe), 32'd1);
      @(negedge clk);
      chk(bus_d_out == {fe_stat, 8'h80} && !bus_ten_n_out && !bus_ctl_n_out,
          "R5 status word", bus_d_out, {fe_stat, 8'h80});
      @(negedge clk);
      chk(bus_ten_n_out == 1'b1 && bus_oe == 1'b1, "R5 single word",
          {30'd0, bus_ten_n_out, bus_oe}, 32'd3);
      lnk_dir = 1'b0;
      #1 chk(bus_oe == 1'b0, "R2 release on direction", 32'(bus_oe), 32'd0);
      @(negedge clk);
    end

    // block write, with a stray data word first
    @(negedge clk);
    lnk_dir = 1'b0; lnk_ben_n = 1'b0; bus_ten_n_in = 1'b0; bus_ctl_n_in = 1'b1;
    bus_d_in = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_ten_n_in = 1'b1;
    chk(wr_valid == 1'b0, "R9 stray data ignored", 32'(wr_valid), 32'd0);
    send_cmd(8'h04, '0);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = word_of(200 + i);
      wr_ready = (i % 3 != 1);
      bus_ten_n_in = 1'b0; bus_ctl_n_in = 1'b1; bus_d_in = w;
      #1 chk(fe_busy_n == wr_ready, "R9 busy follows ready", 32'(fe_busy_n), 32'(wr_ready));
      @(negedge clk);
      bus_ten_n_in = 1'b1;
      chk(wr_valid == 1'b1 && wr_data == w, "R9 write data", wr_data, w);
    end
    @(negedge clk);
    chk(wr_valid == 1'b0, "R9 no word no strobe", 32'(wr_valid), 32'd0);
    wr_ready = 1'b0;
    send_cmd(8'h06, '0);
    #1 chk(fe_busy_n == 1'b1, "R9 busy idle", 32'(fe_busy_n), 32'd1);
    wr_ready = 1'b1;

    // event and block read sweeps
    for (int fm = 0; fm < 2; fm++)
      for (int s = 1; s <= 4; s++)
        for (int nb = 1; nb <= 3; nb++)
          run_stream(1'b1, nb, s, fm);
    for (int s = 1; s <= 4; s++) run_stream(1'b0, 3, s, s % 2);

    // grant withdrawn mid-stream
    load_fifo(1, 10);
    gap_exact = 1;
    mon_on = 1;
    send_cmd(8'h03, '0);
    lnk_dir = 1'b1;
    for (int c = 0; c < 100 && mon_words < 3; c++) @(negedge clk);
    lnk_full_n = 1'b0;
    repeat (2) @(negedge clk);
    lnk_dir = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1 chk(bus_oe == 1'b0 && ev_pop == 1'b0, "R12 released while withdrawn",
             {30'd0, bus_oe, ev_pop}, 32'd0);
      @(negedge clk);
    end
    lnk_dir = 1'b1; lnk_full_n = 1'b1;
    for (int c = 0; c < 100 && mon_sts < 1; c++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(mon_words == 10, "R12 no word lost", 32'(mon_words), 32'd10);
    close_and_idle();

    finish_up();
  end
endmodule